// File: doc/BRIEF.md
# SDRAM Read/Write Burst Sequencer

This block runs on the controller side of a single-data-rate SDRAM. It holds a 10-bit mode word and uses it to time read and write bursts. For each READ or WRITE command, together with the column address it carries, the block produces per-cycle control strobes:

- a one-cycle flag that tells the data path to start driving the bus ahead of read data,
- a read-valid strobe with the beat index and the column of each beat,
- a write-accept strobe with the column of each write beat.

The mode word sets four things: the burst length, the beat order (sequential or interleaved), the read latency of one to three cycles, and whether writes are single-beat. The block rejects reserved or test settings and any load made while a burst is in flight. A rejected load raises an error flag and leaves the mode unchanged.

Mode word layout:

| Bits | Meaning | Codes |
|------|---------|-------|
| [2:0] | Burst length | 000=1, 001=2, 010=4, 011=8; others reserved |
| [3] | Beat order | 0 = sequential, 1 = interleaved |
| [6:4] | Read latency | 001=1, 010=2, 011=3; others reserved |
| [8:7] | Operating mode | must be 00 |
| [9] | Write mode | 1 = single-beat writes |

Timing reference: a command is registered at edge n when it is held high just before that edge. "Cycle k" is the clock cycle that begins at edge k.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset all output strobes are low and `mode_err_o` is 0. The mode word is 10'h010: burst length 1, latency 1, sequential order, writes burst.
- R2: A READ registered at edge n with latency m raises `drive_o` for cycle n+m-1 only. The first read beat (`rd_valid_o`=1, `rd_idx_o`=0) is in cycle n+m.
- R3: A read burst gives `rd_valid_o` in consecutive cycles. The beat count is set by bits [2:0], and `rd_idx_o` counts 0 up to length-1.
- R4: With bit [3]=0, the column of beat i keeps the address bits above log2(length). Its low log2(length) bits are (start + i) mod length.
- R5: With bit [3]=1, the low log2(length) bits of the column of beat i are the start's low bits XOR i.
- R6: A WRITE registered at edge n raises `wr_accept_o` from cycle n for the programmed burst length. It reports each beat's column in the order of R4/R5.
- R7: With bit [9]=1, each WRITE gives exactly one accept beat at the command's column, while reads still burst at full length.
- R8: A load whose bits [8:7] are not 00 is ignored and sets `mode_err_o` from the cycle after the load.
- R9: A load with a reserved latency code or burst-length code is ignored and sets `mode_err_o`.
- R10: A load is ignored and sets `mode_err_o` if, in the cycle it is presented, any of these holds: a read is pending or bursting, a write is bursting, or a command is presented. An accepted load clears `mode_err_o`.
- R11: A new READ replaces a read burst in progress when its first beat arrives. It ends a write burst from the cycle it is registered.
- R12: A WRITE registered at edge n cancels every pending read and any read burst from cycle n on, including a read whose first beat would start at edge n. `rd_valid_o` and `wr_accept_o` are never high together.
- R13: If READ and WRITE are presented at the same edge, the READ is taken and the WRITE is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Mode word load request |
| mode_word_i | input | 10 | Mode word to load |
| rd_i | input | 1 | READ command strobe |
| wr_i | input | 1 | WRITE command strobe |
| col_i | input | COL_W | Column address of the command |
| drive_o | output | 1 | Start driving the data bus (one cycle before the first read beat) |
| rd_valid_o | output | 1 | Read beat valid |
| rd_idx_o | output | 3 | Beat index within the read burst |
| rd_col_o | output | COL_W | Column of the current read beat |
| wr_accept_o | output | 1 | Write beat accepted |
| wr_col_o | output | COL_W | Column of the current write beat |
| mode_err_o | output | 1 | The last mode load was rejected |

## Verification
Three pairs of events can fall on the same clock edge. This section covers how each pair is provoked and judged.

- Write meets a read launch. The bench schedules a WRITE for the exact edge at which a pending read would deliver its first beat. No read beat may appear, and the write burst must start in that cycle.
- READ and WRITE together. The bench presents both on one edge. It expects only the read burst.
- Mode load meets a command. The bench presents a mode load in the same cycle as a READ. The load must be rejected, so the following bursts must still follow the old mode and `mode_err_o` must be set.

All expected strobes and columns are built per cycle from the latency, length and order rules.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int IDX_W  = 3;
  localparam int MAX_CL = 3;
  localparam int MODE_W = 10;
  localparam logic [MODE_W-1:0] MODE_RST = 10'h010;

  typedef struct packed {
    logic       wr_single;
    logic [1:0] opmode;
    logic [2:0] cl;
    logic       ilv;
    logic [2:0] blc;
  } mode_t;

  function automatic logic word_legal(input mode_t m);
    return (m.opmode == 2'b00) && (m.cl inside {3'd1, 3'd2, 3'd3}) && !m.blc[2];
  endfunction

  function automatic logic [IDX_W-1:0] last_idx(input logic [1:0] blc);
    case (blc)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/seq_burst_col.sv
module seq_burst_col
  import sdram_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       blc_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  localparam int HI_W = COL_W - IDX_W;

  logic [IDX_W-1:0] mask, low, nxt;

  always_comb begin
    mask  = last_idx(blc_i);
    low   = base_i[IDX_W-1:0] & mask;
    nxt   = ilv_i ? (low ^ idx_i) : (low + idx_i);
    col_o = {base_i[COL_W-1:COL_W-HI_W], (base_i[IDX_W-1:0] & ~mask) | (nxt & mask)};
  end
endmodule

// File: rtl/seq_mode_reg.sv
module seq_mode_reg
  import sdram_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] word_i,
  input  logic              busy_i,
  output mode_t             mode_o,
  output logic              err_o
);
  mode_t mode_q;
  logic  take;

  assign take   = we_i && !busy_i && word_legal(mode_t'(word_i));
  assign mode_o = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= mode_t'(MODE_RST);
      err_o  <= 1'b0;
    end else if (we_i) begin
      err_o <= !take;
      if (take) mode_q <= mode_t'(word_i);
    end
  end

  assert_illegal_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (word_i[8:7] != 2'b00) |=> $stable(mode_q) && err_o);

  assert_reserved_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (word_i[2] || !(word_i[6:4] inside {3'd1, 3'd2, 3'd3})) |=> $stable(mode_q) && err_o);

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && busy_i |=> $stable(mode_q) && err_o);
endmodule

// File: rtl/seq_read_path.sv
module seq_read_path
  import sdram_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] col_i,
  input  mode_t            mode_i,
  output logic             drive_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [COL_W-1:0] col_o,
  output logic             busy_o
);
  logic             pipe_vld [MAX_CL];
  logic [COL_W-1:0] pipe_col [MAX_CL];
  logic [1:0]       sel;
  logic             cancel, launch, any_pend;
  logic             act_q;
  logic [IDX_W-1:0] idx_q, last;
  logic [COL_W-1:0] base_q;

  assign sel    = mode_i.cl[1:0] - 2'd1;
  assign cancel = wr_i && !rd_i;
  assign launch = pipe_vld[sel] && !cancel;
  assign last   = last_idx(mode_i.blc[1:0]);

  always_comb begin
    any_pend = 1'b0;
    for (int k = 0; k < MAX_CL; k++) any_pend = any_pend | pipe_vld[k];
  end

  // latency pipeline: stage k holds a command registered k+1 edges ago
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_CL; k++) begin
        pipe_vld[k] <= 1'b0;
        pipe_col[k] <= '0;
      end
    end else begin
      pipe_vld[0] <= rd_i;
      pipe_col[0] <= col_i;
      for (int k = 1; k < MAX_CL; k++) begin
        pipe_vld[k] <= cancel ? 1'b0 : pipe_vld[k-1];
        pipe_col[k] <= pipe_col[k-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (cancel) begin
      act_q <= 1'b0;
    end else if (launch) begin
      act_q  <= 1'b1;
      idx_q  <= '0;
      base_q <= pipe_col[sel];
    end else if (act_q) begin
      if (idx_q == last) act_q <= 1'b0;
      else               idx_q <= idx_q + 1'b1;
    end
  end

  seq_burst_col #(.COL_W(COL_W)) u_col (
    .base_i(base_q),
    .idx_i (idx_q),
    .blc_i (mode_i.blc[1:0]),
    .ilv_i (mode_i.ilv),
    .col_o (col_o)
  );

  assign drive_o = pipe_vld[sel];
  assign valid_o = act_q;
  assign idx_o   = idx_q;
  assign busy_o  = any_pend || act_q;

  assert_drive_lead_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(drive_o));

  assert_idx_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> idx_o <= last);

  assert_beats_contiguous_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (idx_o != '0) |-> $past(valid_o) && (idx_o == $past(idx_o) + 3'd1));
endmodule

// File: rtl/seq_write_path.sv
module seq_write_path
  import sdram_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] col_i,
  input  mode_t            mode_i,
  output logic             accept_o,
  output logic [COL_W-1:0] col_o,
  output logic             busy_o
);
  logic             start, act_q;
  logic [IDX_W-1:0] idx_q, last;
  logic [COL_W-1:0] base_q;

  assign start = wr_i && !rd_i;
  assign last  = mode_i.wr_single ? '0 : last_idx(mode_i.blc[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      idx_q  <= '0;
      base_q <= col_i;
    end else if (rd_i) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (idx_q == last) act_q <= 1'b0;
      else               idx_q <= idx_q + 1'b1;
    end
  end

  seq_burst_col #(.COL_W(COL_W)) u_col (
    .base_i(base_q),
    .idx_i (idx_q),
    .blc_i (mode_i.blc[1:0]),
    .ilv_i (mode_i.ilv),
    .col_o (col_o)
  );

  assign accept_o = act_q;
  assign busy_o   = act_q;

  assert_single_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && mode_i.wr_single |-> col_o == base_q && idx_q == '0);

  assert_rd_ends_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !accept_o);
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic [9:0]       mode_word_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] col_i,
  output logic             drive_o,
  output logic             rd_valid_o,
  output logic [2:0]       rd_idx_o,
  output logic [COL_W-1:0] rd_col_o,
  output logic             wr_accept_o,
  output logic [COL_W-1:0] wr_col_o,
  output logic             mode_err_o
);
  mode_t mode;
  logic  rd_busy, wr_busy, busy;

  assign busy = rd_i || wr_i || rd_busy || wr_busy;

  seq_mode_reg u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (mode_we_i),
    .word_i(mode_word_i),
    .busy_i(busy),
    .mode_o(mode),
    .err_o (mode_err_o)
  );

  seq_read_path #(.COL_W(COL_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .col_i  (col_i),
    .mode_i (mode),
    .drive_o(drive_o),
    .valid_o(rd_valid_o),
    .idx_o  (rd_idx_o),
    .col_o  (rd_col_o),
    .busy_o (rd_busy)
  );

  seq_write_path #(.COL_W(COL_W)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .col_i   (col_i),
    .mode_i  (mode),
    .accept_o(wr_accept_o),
    .col_o   (wr_col_o),
    .busy_o  (wr_busy)
  );

  assert_no_bus_clash_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && wr_accept_o));

  assert_wr_cancels_rd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !rd_i |=> !rd_valid_o && !drive_o);
endmodule

// File: tb/tb_sdram_burst_seq.sv
`timescale 1ns/1ps
module tb_sdram_burst_seq;
  localparam int N = 24;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_we_i = 1'b0;
  logic [9:0] mode_word_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] col_i = '0;
  logic       drive_o, rd_valid_o, wr_accept_o, mode_err_o;
  logic [2:0] rd_idx_o;
  logic [7:0] rd_col_o, wr_col_o;

  always #5 clk_i = ~clk_i;

  sdram_burst_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_word_i(mode_word_i),
    .rd_i(rd_i), .wr_i(wr_i), .col_i(col_i), .drive_o(drive_o), .rd_valid_o(rd_valid_o),
    .rd_idx_o(rd_idx_o), .rd_col_o(rd_col_o), .wr_accept_o(wr_accept_o),
    .wr_col_o(wr_col_o), .mode_err_o(mode_err_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // schedule (inputs at step t are registered at edge t) and per-cycle records
  bit         s_rd [N], s_wr [N], s_we [N];
  logic [7:0] s_col [N];
  logic [9:0] s_mode [N];
  bit         o_drv [N], o_rv [N], o_wa [N], o_err [N];
  int         o_ridx [N], o_rcol [N], o_wcol [N];
  bit         e_drv [N], e_rv [N], e_wa [N];
  int         e_ridx [N], e_rcol [N], e_wcol [N];

  int m_bl, m_cl;
  bit m_ilv, m_single;

  // vector: {mode word, is_write, column}
  localparam logic [18:0] VEC [8] = '{
    {10'h022, 1'b0, 8'h1E}, {10'h03B, 1'b0, 8'h35}, {10'h011, 1'b1, 8'h41},
    {10'h013, 1'b1, 8'h0D}, {10'h23A, 1'b1, 8'h66}, {10'h23A, 1'b0, 8'h66},
    {10'h020, 1'b0, 8'h7F}, {10'h023, 1'b0, 8'hFB}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_model(input logic [9:0] w);
    m_bl     = 1 << w[2:0];
    m_ilv    = w[3];
    m_cl     = int'(w[6:4]);
    m_single = w[9];
  endtask

  function automatic int ecol(input int base, input int i);
    int low = base % m_bl;
    int nl  = m_ilv ? (low ^ i) : ((low + i) % m_bl);
    return base - low + nl;
  endfunction

  task automatic clear_all();
    for (int c = 0; c < N; c++) begin
      s_rd[c] = 0; s_wr[c] = 0; s_we[c] = 0; s_col[c] = '0; s_mode[c] = '0;
      e_drv[c] = 0; e_rv[c] = 0; e_wa[c] = 0; e_ridx[c] = 0; e_rcol[c] = 0; e_wcol[c] = 0;
    end
  endtask

  task automatic exp_read(input int s, input int col);
    for (int c = s; c < N; c++) e_wa[c] = 0;
    for (int c = s + m_cl; c < N; c++) e_rv[c] = 0;
    if (s + m_cl - 1 < N) e_drv[s + m_cl - 1] = 1;
    for (int i = 0; i < m_bl; i++)
      if (s + m_cl + i < N) begin
        e_rv[s + m_cl + i] = 1; e_ridx[s + m_cl + i] = i; e_rcol[s + m_cl + i] = ecol(col, i);
      end
  endtask

  task automatic exp_write(input int s, input int col);
    int len = m_single ? 1 : m_bl;
    for (int c = s; c < N; c++) begin e_drv[c] = 0; e_rv[c] = 0; e_wa[c] = 0; end
    for (int i = 0; i < len; i++)
      if (s + i < N) begin e_wa[s + i] = 1; e_wcol[s + i] = ecol(col, i); end
  endtask

  task automatic run_seq();
    for (int t = 0; t <= N; t++) begin
      @(negedge clk_i);
      if (t > 0) begin
        o_drv[t-1] = drive_o; o_rv[t-1] = rd_valid_o; o_ridx[t-1] = int'(rd_idx_o);
        o_rcol[t-1] = int'(rd_col_o); o_wa[t-1] = wr_accept_o; o_wcol[t-1] = int'(wr_col_o);
        o_err[t-1] = mode_err_o;
      end
      if (t < N) begin
        rd_i = s_rd[t]; wr_i = s_wr[t]; col_i = s_col[t];
        mode_we_i = s_we[t]; mode_word_i = s_mode[t];
      end else begin
        rd_i = 0; wr_i = 0; col_i = '0; mode_we_i = 0; mode_word_i = '0;
      end
    end
  endtask

  task automatic compare(input string rq, input string wq);
    for (int c = 0; c < N; c++) begin
      chk(o_drv[c] == e_drv[c], rq, $sformatf("drive c%0d", c), o_drv[c], e_drv[c]);
      chk(o_rv[c] == e_rv[c], rq, $sformatf("rd_valid c%0d", c), o_rv[c], e_rv[c]);
      if (e_rv[c]) begin
        chk(o_ridx[c] == e_ridx[c], rq, $sformatf("rd_idx c%0d", c), o_ridx[c], e_ridx[c]);
        chk(o_rcol[c] == e_rcol[c], rq, $sformatf("rd_col c%0d", c), o_rcol[c], e_rcol[c]);
      end
      chk(o_wa[c] == e_wa[c], wq, $sformatf("wr_accept c%0d", c), o_wa[c], e_wa[c]);
      if (e_wa[c])
        chk(o_wcol[c] == e_wcol[c], wq, $sformatf("wr_col c%0d", c), o_wcol[c], e_wcol[c]);
    end
  endtask

  // load attempt at step 0, then a read at step 3 under the expected mode
  task automatic bad_load(input logic [9:0] w, input string req, input int col);
    clear_all();
    s_we[0] = 1; s_mode[0] = w;
    s_rd[3] = 1; s_col[3] = 8'(col);
    exp_read(3, col);
    run_seq();
    compare(req, req);
    chk(o_err[N-1] == 1, req, "mode_err", o_err[N-1], 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1: reset state
    chk(!drive_o && !rd_valid_o && !wr_accept_o, "R1", "strobes after reset",
        {drive_o, rd_valid_o, wr_accept_o}, 0);
    chk(mode_err_o == 0, "R1", "mode_err after reset", mode_err_o, 0);

    // R1: default mode BL1 CL1 sequential
    set_model(10'h010);
    clear_all();
    s_rd[0] = 1; s_col[0] = 8'h05;
    exp_read(0, 8'h05);
    run_seq();
    compare("R1", "R1");

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      clear_all();
      s_we[0] = 1; s_mode[0] = VEC[i][18:9];
      set_model(VEC[i][18:9]);
      if (VEC[i][8]) begin
        s_wr[2] = 1; s_col[2] = VEC[i][7:0]; exp_write(2, VEC[i][7:0]);
      end else begin
        s_rd[2] = 1; s_col[2] = VEC[i][7:0]; exp_read(2, VEC[i][7:0]);
      end
      run_seq();
      compare("R2 R3 R4 R5 R7", "R6 R7");
      chk(o_err[N-1] == 0, "R10", "mode_err after legal load", o_err[N-1], 0);
    end

    // mode now 0x023: BL8 CL2 sequential
    bad_load(10'h0A2, "R8", 8'h09);
    bad_load(10'h122, "R8", 8'h0C);
    bad_load(10'h002, "R9", 8'h11);
    bad_load(10'h042, "R9", 8'h2A);
    bad_load(10'h024, "R9", 8'h3D);

    // R10: legal load clears the error
    clear_all();
    s_we[0] = 1; s_mode[0] = 10'h011;
    set_model(10'h011);
    s_rd[2] = 1; s_col[2] = 8'h33; exp_read(2, 8'h33);
    run_seq();
    compare("R10", "R10");
    chk(o_err[N-1] == 0, "R10", "err cleared", o_err[N-1], 0);

    // R10: load during a burst is rejected
    clear_all();
    s_rd[0] = 1; s_col[0] = 8'h10; exp_read(0, 8'h10);
    s_we[2] = 1; s_mode[2] = 10'h013;
    s_rd[6] = 1; s_col[6] = 8'h17; exp_read(6, 8'h17);
    run_seq();
    compare("R10", "R10");
    chk(o_err[N-1] == 1, "R10", "err after busy load", o_err[N-1], 1);

    // R10: load in the same cycle as a command is rejected
    clear_all();
    s_rd[0] = 1; s_col[0] = 8'h20; s_we[0] = 1; s_mode[0] = 10'h013;
    exp_read(0, 8'h20);
    s_rd[5] = 1; s_col[5] = 8'h2B; exp_read(5, 8'h2B);
    run_seq();
    compare("R10", "R10");
    chk(o_err[N-1] == 1, "R10", "err after same-cycle load", o_err[N-1], 1);

    // switch to BL8 CL2 sequential
    clear_all();
    s_we[0] = 1; s_mode[0] = 10'h023;
    set_model(10'h023);
    run_seq();
    chk(o_err[N-1] == 0, "R10", "err cleared again", o_err[N-1], 0);

    // R11: read truncates read burst
    clear_all();
    s_rd[0] = 1; s_col[0] = 8'h10; exp_read(0, 8'h10);
    s_rd[3] = 1; s_col[3] = 8'h25; exp_read(3, 8'h25);
    run_seq();
    compare("R11", "R11");

    // R11: read ends a write burst
    clear_all();
    s_wr[0] = 1; s_col[0] = 8'h30; exp_write(0, 8'h30);
    s_rd[2] = 1; s_col[2] = 8'h40; exp_read(2, 8'h40);
    run_seq();
    compare("R11", "R11");

    // R12: write lands on the edge the pending read would launch
    clear_all();
    s_rd[0] = 1; s_col[0] = 8'h50; exp_read(0, 8'h50);
    s_wr[2] = 1; s_col[2] = 8'h60; exp_write(2, 8'h60);
    run_seq();
    compare("R12", "R12");

    // R12: write cancels a read before its drive cycle
    clear_all();
    s_rd[0] = 1; s_col[0] = 8'h52; exp_read(0, 8'h52);
    s_wr[1] = 1; s_col[1] = 8'h64; exp_write(1, 8'h64);
    run_seq();
    compare("R12", "R12");

    // R13: simultaneous read and write
    clear_all();
    s_rd[0] = 1; s_wr[0] = 1; s_col[0] = 8'h70; exp_read(0, 8'h70);
    run_seq();
    compare("R13", "R13");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule